// File: doc/BRIEF.md
# Multiframe Clock Counter with SYSREF Realignment

This block keeps the local multiframe phase of a converter link receiver. It runs in the link clock domain. A counter steps through 0 up to a programmable limit, which is the multiframe length in link clocks minus one (F×K/4 − 1). The block emits a one-cycle tick on the last count of every multiframe. Downstream logic uses the count and the tick to schedule alignment, buffer release and synchronisation events.

A sampled SYSREF level can realign the counter in two ways. In single-shot mode, software sets an arm bit. The first rising edge then realigns the counter, and the block pulses a clear output so that the arm bit drops. The same event sets a sticky flag that records that SYSREF has been seen. In continuous mode, every rising edge realigns the counter. The block also checks that the spacing between edges is a whole number of multiframes, and it pulses an error when the spacing is wrong.

A realignment loads a programmable start offset instead of zero. If the offset lies beyond the limit, the counter loads zero.

Top module: `lmfc_align_top`

## Requirements
- R1: After reset, the count rises by one every cycle. It never exceeds `lmfc_last` while `lmfc_last` is held constant.
- R2: `lmfc_tick` is 1 in exactly the cycle where the count equals `lmfc_last`. In the following cycle the count is 0, unless a realignment occurs.
- R3: A realignment loads `align_offset` into the count. If `align_offset` is greater than `lmfc_last`, the count loads 0. The new value is visible one cycle after the clock edge that first samples `sysref_lvl` high following a low sample.
- R4: A rising edge of `sysref_lvl` while `single_arm` is 1 realigns the counter. In the same cycle as the load, `single_clear` is 1 for exactly one cycle.
- R5: While `single_arm` and `cont_en` are both 0, rising edges of `sysref_lvl` have no effect: the count keeps stepping and `single_clear` stays 0.
- R6: `sysref_seen` becomes 1 together with `single_clear` and holds. It returns to 0 one cycle after `single_arm` rises from 0 to 1, unless an armed edge happens in that same cycle.
- R7: While `cont_en` is 1, every rising edge of `sysref_lvl` realigns the counter, whatever the value of `single_arm`.
- R8: In continuous mode, an edge that arrives a number of cycles after the previous continuous-mode edge that is not a multiple of `lmfc_last`+1 makes `period_err` 1 for one cycle, in the same cycle as the load. The first edge after `cont_en` rises is never flagged.
- R9: While `rst_n` is 0, all outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sysref_lvl | input | 1 | SYSREF level, already sampled in the link clock domain |
| lmfc_last | input | W | Multiframe length in link clocks minus one |
| align_offset | input | W | Count loaded on realignment |
| single_arm | input | 1 | Arms single-shot realignment |
| cont_en | input | 1 | Enables continuous realignment and the period check |
| lmfc_count | output | W | Current multiframe count |
| lmfc_tick | output | 1 | High on the last count of the multiframe |
| sysref_seen | output | 1 | Sticky flag: an armed edge was sampled |
| single_clear | output | 1 | One-cycle request to clear the arm bit |
| period_err | output | 1 | One-cycle SYSREF spacing error |

## Verification
The assertions rely on three assumptions about the inputs:
- SYSREF is never high in two consecutive rising-edge detections, since each edge needs a low sample between highs.
- `lmfc_last` and `align_offset` are steady in the cycle before and the cycle of each edge.
- The bound check applies only while `lmfc_last` has not just changed.

The stimulus respects all three. It changes the limit, the offset and the mode bits one negative edge before it raises SYSREF. It holds every pulse high for exactly one cycle. It lowers the arm bit only after the clear has been observed.

// File: rtl/lmfc_pkg.sv
package lmfc_pkg;
   localparam int unsigned LMFC_MAX_W = 16;

   // one-cycle events derived from the SYSREF edge
   typedef struct packed {
      logic rise;       // 0 -> 1 transition of the sampled level
      logic realign;    // rise that is allowed to reload the counter
      logic armed_hit;  // rise consumed by the single-shot arm
   } sysref_evt_t;
endpackage

// File: rtl/lmfc_sysref_edge.sv
module lmfc_sysref_edge
   import lmfc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sysref_lvl,
   input  logic        single_arm,
   input  logic        cont_en,
   output sysref_evt_t evt
);
   logic lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= sysref_lvl;
   end

   always_comb begin
      evt.rise      = sysref_lvl & ~lvl_q;
      evt.realign   = evt.rise & (single_arm | cont_en);
      evt.armed_hit = evt.rise & single_arm;
   end
endmodule

// File: rtl/lmfc_count_core.sv
module lmfc_count_core #(
   parameter int unsigned W            = 8,
   parameter bit          OFFSET_CLAMP = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lmfc_last,
   input  logic [W-1:0] align_offset,
   input  logic         realign,
   output logic [W-1:0] count,
   output logic [W-1:0] load_val,
   output logic [W-1:0] next_free,
   output logic         tick
);
   localparam logic [W-1:0] ONE = W'(1);

   // variant choice for the value loaded on realignment
   generate
      if (OFFSET_CLAMP) begin : g_clamp
         assign load_val = (align_offset > lmfc_last) ? '0 : align_offset;
      end else begin : g_raw
         assign load_val = align_offset;
      end
   endgenerate

   // free-running successor; >= also recovers when the limit shrinks
   assign next_free = (count >= lmfc_last) ? '0 : count + ONE;

   always_ff @(posedge clk) begin
      if (!rst_n)       count <= '0;
      else if (realign) count <= load_val;
      else              count <= next_free;
   end

   assign tick = rst_n & (count == lmfc_last);
endmodule

// File: rtl/lmfc_period_chk.sv
module lmfc_period_chk #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cont_en,
   input  logic         rise,
   input  logic [W-1:0] next_free,
   input  logic [W-1:0] load_val,
   output logic         period_err
);
   logic primed;

   always_ff @(posedge clk) begin
      if (!rst_n || !cont_en) begin
         primed     <= 1'b0;
         period_err <= 1'b0;
      end else begin
         // on a whole-multiframe spacing the free count already equals the load
         period_err <= rise & primed & (next_free != load_val);
         if (rise) primed <= 1'b1;
      end
   end
endmodule

// File: rtl/lmfc_align_top.sv
module lmfc_align_top
   import lmfc_pkg::*;
#(
   parameter int unsigned W            = 8,
   parameter bit          OFFSET_CLAMP = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sysref_lvl,
   input  logic [W-1:0] lmfc_last,
   input  logic [W-1:0] align_offset,
   input  logic         single_arm,
   input  logic         cont_en,
   output logic [W-1:0] lmfc_count,
   output logic         lmfc_tick,
   output logic         sysref_seen,
   output logic         single_clear,
   output logic         period_err
);
   generate
      if (W < 2 || W > LMFC_MAX_W) begin : g_bad_width
         $error("lmfc_align_top: W out of range");
      end
   endgenerate

   sysref_evt_t  evt;
   logic [W-1:0] load_val;
   logic [W-1:0] next_free;
   logic         arm_q;
   logic         realign;

   assign realign = evt.realign;

   lmfc_sysref_edge u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .sysref_lvl (sysref_lvl),
      .single_arm (single_arm),
      .cont_en    (cont_en),
      .evt        (evt)
   );

   lmfc_count_core #(.W(W), .OFFSET_CLAMP(OFFSET_CLAMP)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .lmfc_last    (lmfc_last),
      .align_offset (align_offset),
      .realign      (evt.realign),
      .count        (lmfc_count),
      .load_val     (load_val),
      .next_free    (next_free),
      .tick         (lmfc_tick)
   );

   lmfc_period_chk #(.W(W)) u_per (
      .clk        (clk),
      .rst_n      (rst_n),
      .cont_en    (cont_en),
      .rise       (evt.rise),
      .next_free  (next_free),
      .load_val   (load_val),
      .period_err (period_err)
   );

   // arm bookkeeping: clear request and sticky seen flag
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q        <= 1'b0;
         single_clear <= 1'b0;
         sysref_seen  <= 1'b0;
      end else begin
         arm_q        <= single_arm;
         single_clear <= evt.armed_hit;
         if (evt.armed_hit)            sysref_seen <= 1'b1;
         else if (single_arm && !arm_q) sysref_seen <= 1'b0;
      end
   end
endmodule

// File: rtl/lmfc_align_chk.sv
module lmfc_align_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] lmfc_last,
   input logic [W-1:0] align_offset,
   input logic         cont_en,
   input logic         realign,
   input logic [W-1:0] lmfc_count,
   input logic         lmfc_tick,
   input logic         sysref_seen,
   input logic         single_clear,
   input logic         period_err
);
   assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(lmfc_last) |-> lmfc_count <= lmfc_last);

   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lmfc_tick && !realign) |=> lmfc_count == '0);

   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      realign |=> lmfc_count == (($past(align_offset) > $past(lmfc_last)) ? '0 : $past(align_offset)));

   assert_clear_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      single_clear |=> !single_clear);

   assert_seen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      single_clear |-> sysref_seen);

   assert_err_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      period_err |-> $past(cont_en));
endmodule

bind lmfc_align_top lmfc_align_chk #(.W(W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .lmfc_last    (lmfc_last),
   .align_offset (align_offset),
   .cont_en      (cont_en),
   .realign      (realign),
   .lmfc_count   (lmfc_count),
   .lmfc_tick    (lmfc_tick),
   .sysref_seen  (sysref_seen),
   .single_clear (single_clear),
   .period_err   (period_err)
);

// File: tb/tb_lmfc_align_top.sv
module tb_lmfc_align_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sysref_lvl = 1'b0;
   logic [W-1:0] lmfc_last = 8'd7;
   logic [W-1:0] align_offset = '0;
   logic         single_arm = 1'b0;
   logic         cont_en = 1'b0;
   logic [W-1:0] lmfc_count;
   logic         lmfc_tick, sysref_seen, single_clear, period_err;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   lmfc_align_top #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .sysref_lvl(sysref_lvl),
      .lmfc_last(lmfc_last), .align_offset(align_offset),
      .single_arm(single_arm), .cont_en(cont_en),
      .lmfc_count(lmfc_count), .lmfc_tick(lmfc_tick),
      .sysref_seen(sysref_seen), .single_clear(single_clear),
      .period_err(period_err)
   );

   // {limit, offset, expected load}
   localparam int NV = 6;
   localparam logic [23:0] VEC [0:NV-1] = '{
      {8'd7,  8'd0,   8'd0},
      {8'd7,  8'd3,   8'd3},
      {8'd7,  8'd7,   8'd7},
      {8'd7,  8'd8,   8'd0},
      {8'd15, 8'd200, 8'd0},
      {8'd3,  8'd2,   8'd2}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // raise for one sample; returns at the negedge after the loading posedge
   task automatic pulse();
      sysref_lvl = 1'b1;
      @(negedge clk);
      sysref_lvl = 1'b0;
   endtask

   function automatic int succ(input int c, input int last);
      return (c >= last) ? 0 : c + 1;
   endfunction

   initial begin
      int c;
      step(3);
      // R9 reset state
      chk("R9 count", lmfc_count, 0);
      chk("R9 tick", lmfc_tick, 0);
      chk("R9 seen", sysref_seen, 0);
      chk("R9 clear", single_clear, 0);
      chk("R9 err", period_err, 0);
      rst_n = 1'b1;
      step(1);
      // R1 stepping and R2 wrap with limit 7
      chk("R1 step", lmfc_count, 1);
      step(6);
      chk("R2 tick at last", lmfc_tick, 1);
      chk("R2 count at last", lmfc_count, 7);
      step(1);
      chk("R2 wrap to zero", lmfc_count, 0);
      chk("R2 tick low", lmfc_tick, 0);

      // table walk: single-shot loads (R3, R4, R6)
      for (int i = 0; i < NV; i++) begin
         lmfc_last    = VEC[i][23:16];
         align_offset = VEC[i][15:8];
         single_arm   = 1'b1;
         step(1);
         pulse();
         chk("R3 load value", lmfc_count, VEC[i][7:0]);
         chk("R4 clear pulse", single_clear, 1);
         chk("R6 seen set", sysref_seen, 1);
         single_arm = 1'b0;
         step(1);
         chk("R4 clear one cycle", single_clear, 0);
         chk("R1 after load", lmfc_count, succ(VEC[i][7:0], VEC[i][23:16]));
         chk("R2 tick follows count",
             lmfc_tick, (succ(VEC[i][7:0], VEC[i][23:16]) == VEC[i][23:16]) ? 1 : 0);
      end

      // R5 unarmed, non-continuous edge ignored
      lmfc_last = 8'd9; align_offset = 8'd4;
      step(3);
      c = lmfc_count;
      pulse();
      chk("R5 edge ignored", lmfc_count, succ(c, 9));
      chk("R5 no clear", single_clear, 0);
      chk("R6 seen holds", sysref_seen, 1);

      // R6 rearm clears seen
      single_arm = 1'b1;
      step(2);
      chk("R6 seen cleared on rearm", sysref_seen, 0);
      single_arm = 1'b0;

      // R7 and R8: continuous mode, limit 7, offset 2
      lmfc_last = 8'd7; align_offset = 8'd2; cont_en = 1'b1;
      step(2);
      pulse();
      chk("R7 first load", lmfc_count, 2);
      chk("R8 first edge unchecked", period_err, 0);
      chk("R7 no clear when unarmed", single_clear, 0);
      step(15);
      pulse();
      chk("R8 multiple spacing ok", period_err, 0);
      chk("R7 reload", lmfc_count, 2);
      step(11);
      pulse();
      chk("R8 bad spacing flagged", period_err, 1);
      chk("R7 reload after bad", lmfc_count, 2);
      step(1);
      chk("R8 error one cycle", period_err, 0);
      cont_en = 1'b0;
      step(1);
      cont_en = 1'b1;
      step(4);
      pulse();
      chk("R8 first edge after enable unchecked", period_err, 0);
      step(4);
      pulse();
      chk("R8 odd spacing flagged again", period_err, 1);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule